// File: doc/BRIEF.md
# Multi-Context Network Interface Register Front-End

This block sits between a memory-mapped access port and the shared receive and transmit engines of a network interface that serves several virtual contexts. Every access carries an address. The bits at and above position 6 choose the context, and the low six bits choose a register within that context's window. The front-end checks each access against the register's declared width and direction. It holds one receive descriptor and one transmit descriptor per context, each guarded by a busy flag and stamped with a tag taken from a free-running counter. Each accepted descriptor write becomes a request in a queue of context indices that the engines drain.

The status words for receive and transmit are assembled at read time from the live FIFO occupancy inputs and the programmable marks. Interrupt status bits gather events from the `irq_src` inputs. A read of the status register clears it, and a write clears only the bits set in both the stored value and the written value. Control, mark, mask and interrupt registers are shared: any context window reaches the same copy.

An access runs through a three-state machine. `ACC_IDLE` accepts a request and moves to `ACC_EXEC`. `ACC_EXEC` decodes the request, applies its side effects and registers the reply, then moves to `ACC_RESP`. `ACC_RESP` presents the reply for one cycle and returns to `ACC_IDLE`. For the engine state inputs, the encoding is: idle = 0, FIFO-block = 1, begin-copy = 2, copy = 3, copy-done = 4.

Top module: `nic_ctx_regfront`

## Requirements
- R1: `req_ready` is high only in `ACC_IDLE`. A request taken at a rising edge is answered with `rsp_valid` high for exactly one cycle, which is the second cycle after the edge that accepted it.
- R2: The context index is `req_addr[ADDR_W-1:6]` and the register offset is `req_addr[5:0]`. A context index of `NCTX` or more is an access error.
- R3: All of the following are access errors: an undefined offset, a write to a read-only register, a read of a write-only register, and a width (`req_wide`: 1 = 8 bytes, 0 = 4 bytes) that differs from the register's width. An erroring access returns `rsp_err` = 1 and data 0, has no side effect, and sets `err_sticky`, which holds until reset.
- R4: The map is as follows. 0x00 CTRL, 4 B, read/write: bit 0 enables receive, bit 1 enables transmit. 0x04 ISTAT, 4 B, read/write. 0x08 IMASK, 4 B, read/write. 0x0C ISET, 4 B, write-only. 0x10 RXMARK, 4 B, read/write. 0x14 TXMARK, 4 B, read/write. 0x18 MAXCOPY, 4 B, read/write. 0x20 RXDESC, 8 B, read/write. 0x28 TXDESC, 8 B, read/write. 0x30 RXSTAT, 8 B, read-only. 0x38 TXSTAT, 8 B, read-only. Writes return data 0, and reads of a descriptor return the stored value.
- R5: A write to a context's descriptor while that context's busy flag is set is an error. An accepted write stores the value, sets busy, and tags the context with the direction's counter, which starts at 0 and then advances by one. A pulse on `rx_done_valid`/`tx_done_valid` clears busy for the named context.
- R6: An accepted receive request pushes its context into the new-packet queue when `rx_ctx_active[ctx]` is 0, and into the continuation queue otherwise.
- R7: `rx_kick` pulses in the response cycle of an accepted receive request only when receive is enabled and `rx_eng_state` is idle (0) or FIFO-block (1).
- R8: An accepted transmit request appends its context to the transmit queue unless that context is already at the head. `tx_kick` pulses in the response cycle only if transmit is enabled, `tx_eng_state` is idle (0), and the queue head after the append equals the context.
- R9: The RXSTAT layout is: [15:0] `rx_pkts_avail`, bit 16 set when `rx_level` is 0, bit 17 set when `rx_level` > RXMARK, bit 18 copied from `rx_low`, bit 31 the context's receive busy flag, and [39:32] its receive tag.
- R10: The TXSTAT layout is: [15:0] `tx_pkts`, bit 16 set when `tx_free` < MAXCOPY, bit 17 set when `tx_level` < TXMARK, bit 31 the context's transmit busy flag, and [39:32] its transmit tag.
- R11: Each cycle, ISTAT ORs in `irq_src`, and `irq` = OR of (ISTAT AND IMASK). A read of ISTAT returns its value and then clears it. A write clears the bits that are set in both ISTAT and the written data. A write to ISET sets the written bits. An event arriving in the same cycle as a clear survives.
- R12: After reset, the following hold: `req_ready` = 1, `rsp_valid` = 0, `irq` = 0, `err_sticky` = 0, no kick, all queues empty, and both enables 0.
- R13: A request aimed at a full queue is refused as an access error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Front-end can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte |
| req_addr | input | ADDR_W | Offset from the block base |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Reply valid |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 64 | Read data |
| err_sticky | output | 1 | An access error occurred since reset |
| ctrl_rx_en | output | 1 | Receive enable |
| ctrl_tx_en | output | 1 | Transmit enable |
| irq_src | input | INT_W | Interrupt events |
| irq | output | 1 | Unmasked interrupt pending |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_pkts_avail | input | 16 | Receive packets available |
| rx_low | input | 1 | Receive below-high indication from the engine |
| rx_ctx_active | input | NCTX | Context has a receive packet in progress |
| rx_eng_state | input | 3 | Receive engine state |
| rx_done_valid | input | 1 | Receive descriptor finished |
| rx_done_ctx | input | CIDX_W | Context of finished receive |
| rx_kick | output | 1 | Start receive engine (FIFO-block) |
| rx_new_valid | output | 1 | New-packet queue not empty |
| rx_new_ctx | output | CIDX_W | New-packet queue head |
| rx_new_pop | input | 1 | Pop new-packet queue |
| rx_cont_valid | output | 1 | Continuation queue not empty |
| rx_cont_ctx | output | CIDX_W | Continuation queue head |
| rx_cont_pop | input | 1 | Pop continuation queue |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| tx_free | input | LVL_W | Transmit FIFO free space |
| tx_pkts | input | 16 | Transmit packets queued |
| tx_eng_state | input | 3 | Transmit engine state |
| tx_done_valid | input | 1 | Transmit descriptor finished |
| tx_done_ctx | input | CIDX_W | Context of finished transmit |
| tx_kick | output | 1 | Start transmit engine |
| tx_q_valid | output | 1 | Transmit queue not empty |
| tx_q_ctx | output | CIDX_W | Transmit queue head |
| tx_q_pop | input | 1 | Pop transmit queue |

## Verification
The collision that matters is an interrupt event that lands in the same cycle as a clear of the status register. The bench raises `irq_src` during the execute cycle of an ISTAT read. It expects the read to return the status from before the event, and a following read to still show the new event bit. A second check applies a masked write-clear after an ISET write. It judges the result through the returned value and through `irq` under two different masks.

// File: rtl/nicf_pkg.sv
package nicf_pkg;

    localparam int REG_SHIFT = 6;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_EXEC,
        ACC_RESP
    } acc_state_e;

    typedef enum logic [2:0] {
        ENG_IDLE       = 3'd0,
        ENG_FIFO_BLOCK = 3'd1,
        ENG_BEGIN_COPY = 3'd2,
        ENG_COPY       = 3'd3,
        ENG_COPY_DONE  = 3'd4
    } eng_state_e;

    typedef enum logic [3:0] {
        RID_CTRL,
        RID_ISTAT,
        RID_IMASK,
        RID_ISET,
        RID_RXMARK,
        RID_TXMARK,
        RID_MAXCOPY,
        RID_RXDESC,
        RID_TXDESC,
        RID_RXSTAT,
        RID_TXSTAT,
        RID_NONE
    } reg_id_e;

    typedef struct packed {
        logic wide;
        logic rd_ok;
        logic wr_ok;
    } reg_attr_t;

    // status word bit positions
    localparam int ST_FLAG_A = 16;
    localparam int ST_FLAG_B = 17;
    localparam int ST_FLAG_C = 18;
    localparam int ST_BUSY   = 31;
    localparam int ST_TAG    = 32;

endpackage

// File: rtl/nicf_decode.sv
module nicf_decode
    import nicf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NCTX   = 4,
    parameter int CIDX_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              wide,
    output logic [CIDX_W-1:0] ctx,
    output reg_id_e           rid,
    output logic              err
);
    localparam int SLOT_W = ADDR_W - REG_SHIFT;

    logic [SLOT_W-1:0]    slot;
    logic [REG_SHIFT-1:0] off;
    reg_attr_t            attr;

    assign slot = addr[ADDR_W-1:REG_SHIFT];
    assign off  = addr[REG_SHIFT-1:0];
    assign ctx  = slot[CIDX_W-1:0];

    always_comb begin
        rid  = RID_NONE;
        attr = '0;
        case (off)
            6'h00: begin rid = RID_CTRL;    attr = '{wide: 1'b0, rd_ok: 1'b1, wr_ok: 1'b1}; end
            6'h04: begin rid = RID_ISTAT;   attr = '{wide: 1'b0, rd_ok: 1'b1, wr_ok: 1'b1}; end
            6'h08: begin rid = RID_IMASK;   attr = '{wide: 1'b0, rd_ok: 1'b1, wr_ok: 1'b1}; end
            6'h0C: begin rid = RID_ISET;    attr = '{wide: 1'b0, rd_ok: 1'b0, wr_ok: 1'b1}; end
            6'h10: begin rid = RID_RXMARK;  attr = '{wide: 1'b0, rd_ok: 1'b1, wr_ok: 1'b1}; end
            6'h14: begin rid = RID_TXMARK;  attr = '{wide: 1'b0, rd_ok: 1'b1, wr_ok: 1'b1}; end
            6'h18: begin rid = RID_MAXCOPY; attr = '{wide: 1'b0, rd_ok: 1'b1, wr_ok: 1'b1}; end
            6'h20: begin rid = RID_RXDESC;  attr = '{wide: 1'b1, rd_ok: 1'b1, wr_ok: 1'b1}; end
            6'h28: begin rid = RID_TXDESC;  attr = '{wide: 1'b1, rd_ok: 1'b1, wr_ok: 1'b1}; end
            6'h30: begin rid = RID_RXSTAT;  attr = '{wide: 1'b1, rd_ok: 1'b1, wr_ok: 1'b0}; end
            6'h38: begin rid = RID_TXSTAT;  attr = '{wide: 1'b1, rd_ok: 1'b1, wr_ok: 1'b0}; end
            default: begin rid = RID_NONE;  attr = '0; end
        endcase
    end

    // R2 / R3: context range, defined offset, direction and width
    always_comb begin
        err = (rid == RID_NONE)
            || (int'(slot) >= NCTX)
            || (write ? !attr.wr_ok : !attr.rd_ok)
            || (wide != attr.wide);
    end

endmodule

// File: rtl/nicf_idx_fifo.sv
module nicf_idx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] head,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop;
    logic             do_push;

    assign valid   = (count != '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign head    = slots[rd_ptr];
    assign do_pop  = pop && valid;
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    // R13: the front-end never pushes into a full queue
    a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

endmodule

// File: rtl/nicf_ctx_bank.sv
module nicf_ctx_bank #(
    parameter int NCTX   = 4,
    parameter int CIDX_W = 2,
    parameter int TAG_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CIDX_W-1:0]            wr_ctx,
    input  logic [63:0]                  wr_data,
    input  logic                         done_valid,
    input  logic [CIDX_W-1:0]            done_ctx,
    output logic [NCTX-1:0][63:0]        desc,
    output logic [NCTX-1:0]              busy,
    output logic [NCTX-1:0][TAG_W-1:0]   tag
);
    logic [TAG_W-1:0] tag_ctr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_ctr <= '0;
        end else if (wr_en) begin
            tag_ctr <= tag_ctr + 1'b1;
        end
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        logic             sel_wr;
        logic             sel_done;
        logic [63:0]      desc_q;
        logic             busy_q;
        logic [TAG_W-1:0] tag_q;

        assign sel_wr   = wr_en && (wr_ctx == CIDX_W'(c));
        assign sel_done = done_valid && (done_ctx == CIDX_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                desc_q <= '0;
                busy_q <= 1'b0;
                tag_q  <= '0;
            end else if (sel_wr) begin
                desc_q <= wr_data;
                busy_q <= 1'b1;
                tag_q  <= tag_ctr;
            end else if (sel_done) begin
                busy_q <= 1'b0;
            end
        end

        assign desc[c] = desc_q;
        assign busy[c] = busy_q;
        assign tag[c]  = tag_q;
    end

    // R5: a descriptor is never overwritten while its context is busy
    a_r5_no_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy[wr_ctx]);

endmodule

// File: rtl/nic_ctx_regfront.sv
module nic_ctx_regfront
    import nicf_pkg::*;
#(
    parameter int NCTX   = 4,
    parameter int ADDR_W = 10,
    parameter int TAG_W  = 8,
    parameter int LVL_W  = 12,
    parameter int INT_W  = 8,
    localparam int CIDX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              err_sticky,
    output logic              ctrl_rx_en,
    output logic              ctrl_tx_en,
    input  logic [INT_W-1:0]  irq_src,
    output logic              irq,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [15:0]       rx_pkts_avail,
    input  logic              rx_low,
    input  logic [NCTX-1:0]   rx_ctx_active,
    input  logic [2:0]        rx_eng_state,
    input  logic              rx_done_valid,
    input  logic [CIDX_W-1:0] rx_done_ctx,
    output logic              rx_kick,
    output logic              rx_new_valid,
    output logic [CIDX_W-1:0] rx_new_ctx,
    input  logic              rx_new_pop,
    output logic              rx_cont_valid,
    output logic [CIDX_W-1:0] rx_cont_ctx,
    input  logic              rx_cont_pop,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  tx_free,
    input  logic [15:0]       tx_pkts,
    input  logic [2:0]        tx_eng_state,
    input  logic              tx_done_valid,
    input  logic [CIDX_W-1:0] tx_done_ctx,
    output logic              tx_kick,
    output logic              tx_q_valid,
    output logic [CIDX_W-1:0] tx_q_ctx,
    input  logic              tx_q_pop
);
    acc_state_e st_q, st_d;

    logic              cap_write;
    logic              cap_wide;
    logic [ADDR_W-1:0] cap_addr;
    logic [63:0]       cap_wdata;

    logic [CIDX_W-1:0] ctx;
    reg_id_e           rid;
    logic              dec_err;

    logic [1:0]        ctrl_q;
    logic [INT_W-1:0]  int_stat_q;
    logic [INT_W-1:0]  int_mask_q;
    logic [LVL_W-1:0]  rx_mark_q;
    logic [LVL_W-1:0]  tx_mark_q;
    logic [LVL_W-1:0]  maxcopy_q;

    logic [NCTX-1:0][63:0]      rx_desc, tx_desc;
    logic [NCTX-1:0]            rx_busy, tx_busy;
    logic [NCTX-1:0][TAG_W-1:0] rx_tag, tx_tag;

    logic rx_new_full, rx_cont_full, tx_q_full;

    logic in_exec;
    logic wr_ok_any;
    logic rx_try, rx_fail, rx_go, rx_to_cont;
    logic tx_try, tx_fail, tx_go, tx_at_head;
    logic acc_err;
    logic rx_kick_d, tx_kick_d;
    logic [63:0] rd_word;
    logic [63:0] rx_stat_w, tx_stat_w;
    logic [INT_W-1:0] int_clr, int_set;

    nicf_decode #(.ADDR_W(ADDR_W), .NCTX(NCTX), .CIDX_W(CIDX_W)) u_decode (
        .addr  (cap_addr),
        .write (cap_write),
        .wide  (cap_wide),
        .ctx   (ctx),
        .rid   (rid),
        .err   (dec_err)
    );

    // ---------------- access state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ACC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_IDLE: if (req_valid) st_d = ACC_EXEC;
            ACC_EXEC: st_d = ACC_RESP;
            ACC_RESP: st_d = ACC_IDLE;
            default:  st_d = ACC_IDLE;
        endcase
    end

    assign req_ready = (st_q == ACC_IDLE);
    assign rsp_valid = (st_q == ACC_RESP);
    assign in_exec   = (st_q == ACC_EXEC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_write <= 1'b0;
            cap_wide  <= 1'b0;
            cap_addr  <= '0;
            cap_wdata <= '0;
        end else if (req_ready && req_valid) begin
            cap_write <= req_write;
            cap_wide  <= req_wide;
            cap_addr  <= req_addr;
            cap_wdata <= req_wdata;
        end
    end

    // ---------------- request routing ----------------
    assign rx_to_cont = rx_ctx_active[ctx];
    assign rx_try     = in_exec && !dec_err && cap_write && (rid == RID_RXDESC);
    assign rx_fail    = rx_try && (rx_busy[ctx] || (rx_to_cont ? rx_cont_full : rx_new_full));
    assign rx_go      = rx_try && !rx_fail;

    assign tx_at_head = tx_q_valid && (tx_q_ctx == ctx);
    assign tx_try     = in_exec && !dec_err && cap_write && (rid == RID_TXDESC);
    assign tx_fail    = tx_try && (tx_busy[ctx] || (!tx_at_head && tx_q_full));
    assign tx_go      = tx_try && !tx_fail;

    assign acc_err    = in_exec && (dec_err || rx_fail || tx_fail);
    assign wr_ok_any  = in_exec && !acc_err && cap_write;

    assign rx_kick_d = rx_go && ctrl_q[0]
                     && ((rx_eng_state == ENG_IDLE) || (rx_eng_state == ENG_FIFO_BLOCK));
    assign tx_kick_d = tx_go && ctrl_q[1] && (tx_eng_state == ENG_IDLE)
                     && (!tx_q_valid || tx_at_head);

    nicf_ctx_bank #(.NCTX(NCTX), .CIDX_W(CIDX_W), .TAG_W(TAG_W)) u_rx_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (rx_go),
        .wr_ctx     (ctx),
        .wr_data    (cap_wdata),
        .done_valid (rx_done_valid),
        .done_ctx   (rx_done_ctx),
        .desc       (rx_desc),
        .busy       (rx_busy),
        .tag        (rx_tag)
    );

    nicf_ctx_bank #(.NCTX(NCTX), .CIDX_W(CIDX_W), .TAG_W(TAG_W)) u_tx_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tx_go),
        .wr_ctx     (ctx),
        .wr_data    (cap_wdata),
        .done_valid (tx_done_valid),
        .done_ctx   (tx_done_ctx),
        .desc       (tx_desc),
        .busy       (tx_busy),
        .tag        (tx_tag)
    );

    nicf_idx_fifo #(.DEPTH(NCTX), .W(CIDX_W)) u_rx_new_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_go && !rx_to_cont),
        .push_data (ctx),
        .pop       (rx_new_pop),
        .valid     (rx_new_valid),
        .head      (rx_new_ctx),
        .full      (rx_new_full)
    );

    nicf_idx_fifo #(.DEPTH(NCTX), .W(CIDX_W)) u_rx_cont_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_go && rx_to_cont),
        .push_data (ctx),
        .pop       (rx_cont_pop),
        .valid     (rx_cont_valid),
        .head      (rx_cont_ctx),
        .full      (rx_cont_full)
    );

    nicf_idx_fifo #(.DEPTH(NCTX), .W(CIDX_W)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_go && !tx_at_head),
        .push_data (ctx),
        .pop       (tx_q_pop),
        .valid     (tx_q_valid),
        .head      (tx_q_ctx),
        .full      (tx_q_full)
    );

    // ---------------- shared registers ----------------
    always_comb begin
        int_clr = '0;
        int_set = irq_src;
        if (in_exec && !acc_err && (rid == RID_ISTAT)) begin
            int_clr = cap_write ? cap_wdata[INT_W-1:0] : '1;
        end
        if (wr_ok_any && (rid == RID_ISET)) begin
            int_set = int_set | cap_wdata[INT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            int_stat_q <= '0;
            int_mask_q <= '0;
            rx_mark_q  <= '0;
            tx_mark_q  <= '0;
            maxcopy_q  <= '0;
        end else begin
            int_stat_q <= (int_stat_q & ~int_clr) | int_set;
            if (wr_ok_any) begin
                case (rid)
                    RID_CTRL:    ctrl_q     <= cap_wdata[1:0];
                    RID_IMASK:   int_mask_q <= cap_wdata[INT_W-1:0];
                    RID_RXMARK:  rx_mark_q  <= cap_wdata[LVL_W-1:0];
                    RID_TXMARK:  tx_mark_q  <= cap_wdata[LVL_W-1:0];
                    RID_MAXCOPY: maxcopy_q  <= cap_wdata[LVL_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign ctrl_rx_en = ctrl_q[0];
    assign ctrl_tx_en = ctrl_q[1];
    assign irq        = |(int_stat_q & int_mask_q);

    // ---------------- status composition ----------------
    always_comb begin
        rx_stat_w                   = '0;
        rx_stat_w[15:0]             = rx_pkts_avail;
        rx_stat_w[ST_FLAG_A]        = (rx_level == '0);
        rx_stat_w[ST_FLAG_B]        = (rx_level > rx_mark_q);
        rx_stat_w[ST_FLAG_C]        = rx_low;
        rx_stat_w[ST_BUSY]          = rx_busy[ctx];
        rx_stat_w[ST_TAG +: TAG_W]  = rx_tag[ctx];

        tx_stat_w                   = '0;
        tx_stat_w[15:0]             = tx_pkts;
        tx_stat_w[ST_FLAG_A]        = (tx_free < maxcopy_q);
        tx_stat_w[ST_FLAG_B]        = (tx_level < tx_mark_q);
        tx_stat_w[ST_BUSY]          = tx_busy[ctx];
        tx_stat_w[ST_TAG +: TAG_W]  = tx_tag[ctx];
    end

    always_comb begin
        case (rid)
            RID_CTRL:    rd_word = 64'(ctrl_q);
            RID_ISTAT:   rd_word = 64'(int_stat_q);
            RID_IMASK:   rd_word = 64'(int_mask_q);
            RID_RXMARK:  rd_word = 64'(rx_mark_q);
            RID_TXMARK:  rd_word = 64'(tx_mark_q);
            RID_MAXCOPY: rd_word = 64'(maxcopy_q);
            RID_RXDESC:  rd_word = rx_desc[ctx];
            RID_TXDESC:  rd_word = tx_desc[ctx];
            RID_RXSTAT:  rd_word = rx_stat_w;
            RID_TXSTAT:  rd_word = tx_stat_w;
            default:     rd_word = '0;
        endcase
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_err    <= 1'b0;
            rsp_rdata  <= '0;
            err_sticky <= 1'b0;
            rx_kick    <= 1'b0;
            tx_kick    <= 1'b0;
        end else begin
            rx_kick <= rx_kick_d;
            tx_kick <= tx_kick_d;
            if (in_exec) begin
                rsp_err   <= acc_err;
                rsp_rdata <= (acc_err || cap_write) ? '0 : rd_word;
                if (acc_err) begin
                    err_sticky <= 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    a_r1_reply_follows_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ACC_EXEC) |=> rsp_valid);

    a_r1_no_accept_during_reply: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    a_r5_busy_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_try && rx_busy[ctx]) |=> rsp_err);

    a_r7_kick_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_kick |=> !rx_kick);

    a_r8_tx_kick_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick |-> tx_q_valid);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && !acc_err && !cap_write && (rid == RID_ISTAT))
        |=> ((int_stat_q & ~$past(irq_src)) == '0));

endmodule

// File: tb/nic_ctx_regfront_bench.sv
module nic_ctx_regfront_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCTX   = 4;
    localparam int ADDR_W = 10;
    localparam int LVL_W  = 12;
    localparam int INT_W  = 8;
    localparam int CIDX_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              req_valid = 0, req_write = 0, req_wide = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_wdata = '0;
    logic              req_ready, rsp_valid, rsp_err, err_sticky;
    logic [63:0]       rsp_rdata;
    logic              ctrl_rx_en, ctrl_tx_en, irq;
    logic [INT_W-1:0]  irq_src = '0;
    logic [LVL_W-1:0]  rx_level = '0, tx_level = '0, tx_free = '0;
    logic [15:0]       rx_pkts_avail = '0, tx_pkts = '0;
    logic              rx_low = 0;
    logic [NCTX-1:0]   rx_ctx_active = '0;
    logic [2:0]        rx_eng_state = 3'd0, tx_eng_state = 3'd0;
    logic              rx_done_valid = 0, tx_done_valid = 0;
    logic [CIDX_W-1:0] rx_done_ctx = '0, tx_done_ctx = '0;
    logic              rx_kick, tx_kick;
    logic              rx_new_valid, rx_cont_valid, tx_q_valid;
    logic [CIDX_W-1:0] rx_new_ctx, rx_cont_ctx, tx_q_ctx;
    logic              rx_new_pop = 0, rx_cont_pop = 0, tx_q_pop = 0;

    nic_ctx_regfront u_nic_ctx_regfront (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .err_sticky(err_sticky), .ctrl_rx_en(ctrl_rx_en), .ctrl_tx_en(ctrl_tx_en),
        .irq_src(irq_src), .irq(irq),
        .rx_level(rx_level), .rx_pkts_avail(rx_pkts_avail), .rx_low(rx_low),
        .rx_ctx_active(rx_ctx_active), .rx_eng_state(rx_eng_state),
        .rx_done_valid(rx_done_valid), .rx_done_ctx(rx_done_ctx), .rx_kick(rx_kick),
        .rx_new_valid(rx_new_valid), .rx_new_ctx(rx_new_ctx), .rx_new_pop(rx_new_pop),
        .rx_cont_valid(rx_cont_valid), .rx_cont_ctx(rx_cont_ctx), .rx_cont_pop(rx_cont_pop),
        .tx_level(tx_level), .tx_free(tx_free), .tx_pkts(tx_pkts),
        .tx_eng_state(tx_eng_state), .tx_done_valid(tx_done_valid),
        .tx_done_ctx(tx_done_ctx), .tx_kick(tx_kick),
        .tx_q_valid(tx_q_valid), .tx_q_ctx(tx_q_ctx), .tx_q_pop(tx_q_pop)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [INT_W-1:0] exec_pulse = '0;

    typedef struct {
        logic        err;
        logic [63:0] data;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pop the scoreboard on every reply
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check("R1 unexpected reply", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " err"}, 64'(rsp_err), 64'(e.err));
                check({e.req, " data"}, rsp_rdata, e.data);
            end
        end
    end

    // driver: returns at the falling edge inside the reply cycle
    task automatic access(input bit wr, input bit wide, input int ctx, input int off,
                          input logic [63:0] wdata, input bit exp_err,
                          input logic [63:0] exp_data, input string req);
        exp_t e;
        e.err = exp_err; e.data = exp_data; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_addr = ADDR_W'(ctx * 64 + off); req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        irq_src = exec_pulse;
        @(negedge clk);
        irq_src = '0;
    endtask

    task automatic wr4(input int ctx, input int off, input logic [63:0] v, input string req);
        access(1'b1, 1'b0, ctx, off, v, 1'b0, 64'd0, req);
    endtask

    task automatic rd4(input int ctx, input int off, input logic [63:0] exp, input string req);
        access(1'b0, 1'b0, ctx, off, 64'd0, 1'b0, exp, req);
    endtask

    task automatic rd8(input int ctx, input int off, input logic [63:0] exp, input string req);
        access(1'b0, 1'b1, ctx, off, 64'd0, 1'b0, exp, req);
    endtask

    task automatic pulse_done(input bit is_tx, input int ctx);
        @(negedge clk);
        if (is_tx) begin tx_done_valid = 1; tx_done_ctx = CIDX_W'(ctx); end
        else begin rx_done_valid = 1; rx_done_ctx = CIDX_W'(ctx); end
        @(negedge clk);
        tx_done_valid = 0; rx_done_valid = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check("watchdog expired", 64'd1, 64'd0);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 req_ready", 64'(req_ready), 64'd1);
        check("R12 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R12 irq/sticky", {62'd0, irq, err_sticky}, 64'd0);
        check("R12 kicks", {62'd0, rx_kick, tx_kick}, 64'd0);
        check("R12 queues", {61'd0, rx_new_valid, rx_cont_valid, tx_q_valid}, 64'd0);
        check("R12 enables", {62'd0, ctrl_rx_en, ctrl_tx_en}, 64'd0);

        // R4 control register
        wr4(0, 6'h00, 64'h3, "R4 ctrl write");
        rd4(2, 6'h00, 64'h3, "R4 ctrl read via other context");
        check("R4 enables", {62'd0, ctrl_rx_en, ctrl_tx_en}, 64'd3);
        check("R3 sticky clear before errors", 64'(err_sticky), 64'd0);

        // R3 access errors
        access(1'b1, 1'b1, 0, 6'h00, 64'h0, 1'b1, 64'd0, "R3 width mismatch write");
        check("R3 sticky set", 64'(err_sticky), 64'd1);
        rd4(0, 6'h00, 64'h3, "R3 refused write had no effect");
        access(1'b0, 1'b0, 0, 6'h1C, 64'h0, 1'b1, 64'd0, "R3 undefined offset");
        access(1'b0, 1'b0, 0, 6'h0C, 64'h0, 1'b1, 64'd0, "R3 read of write-only");
        access(1'b1, 1'b1, 0, 6'h30, 64'h5, 1'b1, 64'd0, "R3 write of read-only");
        // R2 context out of range
        access(1'b0, 1'b0, 5, 6'h00, 64'h0, 1'b1, 64'd0, "R2 context beyond NCTX");

        // R5/R6/R7 receive path
        access(1'b1, 1'b1, 0, 6'h20, 64'h1234_5678_9ABC_DEF0, 1'b0, 64'd0, "R5 rx desc ctx0");
        check("R7 kick from idle", 64'(rx_kick), 64'd1);
        check("R6 new queue head", {62'd0, rx_new_valid, rx_new_ctx[0]}, 64'h2);
        check("R6 cont queue empty", 64'(rx_cont_valid), 64'd0);
        rd8(0, 6'h20, 64'h1234_5678_9ABC_DEF0, "R4 rx desc readback");
        access(1'b1, 1'b1, 0, 6'h20, 64'h1, 1'b1, 64'd0, "R5 busy rx desc refused");
        check("R7 no kick on refused", 64'(rx_kick), 64'd0);
        rx_ctx_active = 4'b0010; rx_eng_state = 3'd3;
        access(1'b1, 1'b1, 1, 6'h20, 64'hAA, 1'b0, 64'd0, "R6 rx desc ctx1 active");
        check("R7 no kick while copying", 64'(rx_kick), 64'd0);
        check("R6 cont queue head", {61'd0, rx_cont_valid, rx_cont_ctx}, 64'h5);
        check("R6 new queue unchanged", {61'd0, rx_new_valid, rx_new_ctx}, 64'h4);
        rx_ctx_active = '0; rx_eng_state = 3'd1;
        access(1'b1, 1'b1, 3, 6'h20, 64'hBB, 1'b0, 64'd0, "R7 rx desc ctx3");
        check("R7 kick from fifo-block", 64'(rx_kick), 64'd1);

        // R9 receive status
        rx_pkts_avail = 16'd5; rx_level = '0; rx_low = 1;
        rd8(1, 6'h30, 64'h0000_0001_8005_0005, "R9 rxstat ctx1 empty/low/busy/tag1");
        wr4(0, 6'h10, 64'd100, "R9 rx mark write");
        pulse_done(1'b0, 0);
        rx_pkts_avail = '0; rx_low = 0; rx_level = 12'd101;
        rd8(0, 6'h30, 64'h0000_0000_0002_0000, "R9 rxstat ctx0 high, busy cleared");
        rx_level = 12'd100;
        rd8(0, 6'h30, 64'h0, "R9 rxstat at mark not high");

        // R7 receive disabled
        wr4(0, 6'h00, 64'h2, "R7 disable rx");
        rx_eng_state = 3'd0;
        access(1'b1, 1'b1, 0, 6'h20, 64'hCC, 1'b0, 64'd0, "R7 rx desc while disabled");
        check("R7 no kick when disabled", 64'(rx_kick), 64'd0);

        // R8 transmit path
        access(1'b1, 1'b1, 2, 6'h28, 64'h22, 1'b0, 64'd0, "R8 tx desc ctx2");
        check("R8 kick on empty queue", 64'(tx_kick), 64'd1);
        check("R8 head ctx2", {61'd0, tx_q_valid, tx_q_ctx}, 64'h6);
        access(1'b1, 1'b1, 3, 6'h28, 64'h33, 1'b0, 64'd0, "R8 tx desc ctx3");
        check("R8 no kick behind head", 64'(tx_kick), 64'd0);
        pulse_done(1'b1, 2);
        access(1'b1, 1'b1, 2, 6'h28, 64'h44, 1'b0, 64'd0, "R8 tx desc ctx2 again");
        check("R8 kick when at head", 64'(tx_kick), 64'd1);
        rd8(2, 6'h38, 64'h0000_0002_8000_0000, "R10 txstat ctx2 busy tag2");
        // R10 transmit status flags
        wr4(0, 6'h18, 64'd64, "R10 maxcopy write");
        wr4(0, 6'h14, 64'd10, "R10 tx mark write");
        tx_pkts = 16'd7; tx_free = 12'd63; tx_level = 12'd9;
        rd8(3, 6'h38, 64'h0000_0001_8003_0007, "R10 txstat ctx3 full/low");
        tx_free = 12'd64; tx_level = 12'd10;
        rd8(3, 6'h38, 64'h0000_0001_8000_0007, "R10 txstat at thresholds");
        // R8 duplicate suppressed: exactly two entries
        @(negedge clk); tx_q_pop = 1;
        @(negedge clk); tx_q_pop = 0;
        check("R8 second entry ctx3", {61'd0, tx_q_valid, tx_q_ctx}, 64'h7);
        @(negedge clk); tx_q_pop = 1;
        @(negedge clk); tx_q_pop = 0;
        check("R8 queue empty after two pops", 64'(tx_q_valid), 64'd0);

        // R11 interrupts
        wr4(0, 6'h08, 64'hFF, "R11 mask all");
        check("R11 no irq yet", 64'(irq), 64'd0);
        @(negedge clk); irq_src = 8'h01;
        @(negedge clk); irq_src = 8'h00;
        check("R11 event raises irq", 64'(irq), 64'd1);
        exec_pulse = 8'h04;
        rd4(0, 6'h04, 64'h01, "R11 read-to-clear with colliding event");
        exec_pulse = 8'h00;
        rd4(0, 6'h04, 64'h04, "R11 colliding event survived");
        rd4(0, 6'h04, 64'h00, "R11 cleared after read");
        check("R11 irq low after clear", 64'(irq), 64'd0);
        wr4(0, 6'h0C, 64'h0F, "R11 software set");
        wr4(0, 6'h04, 64'h35, "R11 masked write clear");
        wr4(0, 6'h08, 64'h02, "R11 mask bit1");
        check("R11 irq on surviving bit", 64'(irq), 64'd1);
        wr4(0, 6'h08, 64'h04, "R11 mask bit2");
        check("R11 no irq on cleared bit", 64'(irq), 64'd0);
        rd4(0, 6'h04, 64'h0A, "R11 status after masked clear");

        // R13 full queue refused: fill the new-packet queue
        wr4(0, 6'h00, 64'h3, "R13 enable");
        pulse_done(1'b0, 3);
        pulse_done(1'b0, 0);
        // queue holds ctx0, ctx3, ctx0 from earlier; one more fills it
        access(1'b1, 1'b1, 2, 6'h20, 64'h1, 1'b0, 64'd0, "R13 fill new queue");
        access(1'b1, 1'b1, 3, 6'h20, 64'h2, 1'b1, 64'd0, "R13 push into full queue");

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 64'(sb_q.size()), 64'd0);
        finished = 1;
        summary();
    end

endmodule